// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block sits between a processor load/store port and a word-wide main-memory port. It holds 512 bytes as sixteen lines of thirty-two bytes. Each line has its own valid flag, dirty flag and stored tag. A request is split into a byte offset, a line index and a tag. The stored tag of the indexed line is compared with the request's tag to decide whether the access hits.

Writes touch only the cached copy and mark the line dirty. A write that misses first pulls the whole line in from memory and then merges the written bytes. When a line must be replaced, its old contents travel back to memory only if the line is dirty. The processor stays stalled until its access completes.

Each line transfer uses eight single-word handshakes at rising word addresses. Once a fill completes, the controller repeats the lookup, so every access ends as a hit on the freshly loaded line.

Top module: `dm_wb_cache`

## Requirements
- R1: After reset every line is invalid, `cpu_ready` and `mem_req` are low, and the first access to any line is a miss; a reset also discards dirty contents without writing them to memory.
- R2: Address bits [4:0] are the byte offset, bits [8:5] the line index and bits [ADDR_W-1:9] the tag. A hit needs the indexed line valid with a stored tag equal to the request tag, whatever the offset.
- R3: An access is accepted at the rising edge where `cpu_req` is seen while the cache is idle. On a hit, `cpu_ready` is high for exactly the following cycle, together with `cpu_hit`.
- R4: A write hit changes only the bytes whose `cpu_be` bit is set (bit n covers data bits 8n+7..8n), sets the line dirty and causes no memory traffic.
- R5: A miss reads the aligned 32-byte block: eight read beats at addresses base, base+4, …, base+28, where base is the request address with bits [4:0] cleared. The lookup is then repeated, `cpu_ready` rises one cycle after the last beat, and `cpu_hit` stays low.
- R6: A miss whose victim line is valid and dirty first sends eight write beats carrying the victim's words to the victim's own block addresses (stored tag, same index), lowest word first. The refill follows directly after.
- R7: A miss whose victim is clean or invalid causes no write beats.
- R8: A write miss allocates the line, merges the enabled bytes into the fetched block and leaves the line dirty.
- R9: For a read, `cpu_rdata` in the `cpu_ready` cycle is the cached 32-bit word selected by address bits [4:2].
- R10: While a miss is in progress `cpu_ready` stays low. `mem_req` together with `mem_addr` and `mem_we` holds steady until `mem_ack`, and `cpu_ready` and `mem_req` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Access request, held with its fields until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Byte address of the access |
| cpu_wdata | input | 32 | Write data |
| cpu_be | input | 4 | Byte enables for writes |
| cpu_ready | output | 1 | One-cycle completion strobe |
| cpu_hit | output | 1 | With `cpu_ready`: access hit on its first lookup |
| cpu_rdata | output | 32 | Read data, valid with `cpu_ready` |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 = write-back beat, 0 = refill beat |
| mem_addr | output | ADDR_W | Word-aligned byte address of the beat |
| mem_wdata | output | 32 | Write-back data |
| mem_ack | input | 1 | Memory accepts the beat (and returns read data) this cycle |
| mem_rdata | input | 32 | Refill data, valid with `mem_ack` |

## Verification
The bench's memory acknowledges each beat in the cycle it is requested. Counted from the rising edge that accepts a request, `cpu_ready` is therefore due in the 1st cycle for a hit, the 10th for a miss with a clean victim and the 18th for a miss with a dirty victim. Every input change and every sample happens on the falling clock edge. At each falling edge inside an access, the bench logs any memory beat and checks its address. It stops at the first falling edge where `cpu_ready` is high, and at that edge it compares the elapsed cycle count, the read-beat and write-beat counts, `cpu_hit` and `cpu_rdata` against its own model. The backing memory is compared word by word against the model's memory image at the end.

// File: rtl/cache_pkg.sv
package cache_pkg;
  localparam int WORD_W = 32;
  localparam int BE_W   = WORD_W / 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CMP   = 2'd1,
    ST_WBACK = 2'd2,
    ST_FILL  = 2'd3
  } cstate_t;

  // byte-lane merge of new data into an old word
  function automatic logic [WORD_W-1:0] merge_word(input logic [WORD_W-1:0] old_w,
                                                  input logic [WORD_W-1:0] new_w,
                                                  input logic [BE_W-1:0]   be);
    logic [WORD_W-1:0] r;
    for (int b = 0; b < BE_W; b++) begin
      r[8*b +: 8] = be[b] ? new_w[8*b +: 8] : old_w[8*b +: 8];
    end
    return r;
  endfunction
endpackage

// File: rtl/cache_tag_store.sv
module cache_tag_store #(
  parameter int LINES = 16,
  parameter int IDX_W = 4,
  parameter int TAG_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  input  logic             fill_en,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             mark_dirty,
  output logic             lk_valid,
  output logic             lk_dirty,
  output logic [TAG_W-1:0] lk_tag
);
  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] dirty_q;
  logic [TAG_W-1:0] tag_q [LINES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (fill_en) begin
      valid_q[idx] <= 1'b1;
      dirty_q[idx] <= 1'b0;
    end else if (mark_dirty) begin
      dirty_q[idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) tag_q[idx] <= fill_tag;
  end

  assign lk_valid = valid_q[idx];
  assign lk_dirty = dirty_q[idx];
  assign lk_tag   = tag_q[idx];
endmodule

// File: rtl/cache_data_store.sv
module cache_data_store
  import cache_pkg::*;
#(
  parameter int LINES  = 16,
  parameter int WPL    = 8,
  parameter int IDX_W  = 4,
  parameter int WSEL_W = 3
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [WSEL_W-1:0] rd_sel,
  output logic [WORD_W-1:0] rd_word,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WSEL_W-1:0] wr_sel,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [BE_W-1:0]   wr_be
);
  localparam int DEPTH = LINES * WPL;

  for (genvar b = 0; b < BE_W; b++) begin : g_lane
    logic [7:0] lane_q [DEPTH];
    always_ff @(posedge clk) begin
      if (wr_en && wr_be[b]) lane_q[{wr_idx, wr_sel}] <= wr_data[8*b +: 8];
    end
    assign rd_word[8*b +: 8] = lane_q[{rd_idx, rd_sel}];
  end
endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
  import cache_pkg::*;
#(
  parameter int WPL    = 8,
  parameter int WSEL_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              lk_valid,
  input  logic              lk_dirty,
  input  logic              lk_match,
  input  logic              mem_ack,
  output cstate_t           state,
  output logic [WSEL_W-1:0] beat,
  output logic              accept,
  output logic              hit_done,
  output logic              first_hit,
  output logic              wb_last,
  output logic              fill_last
);
  localparam logic [WSEL_W-1:0] LAST = WSEL_W'(WPL - 1);

  cstate_t state_d;
  logic    missed_q;
  logic    lookup_hit;

  assign lookup_hit = lk_valid && lk_match;
  assign accept     = (state == ST_IDLE) && cpu_req;
  assign hit_done   = (state == ST_CMP) && lookup_hit;
  assign first_hit  = hit_done && !missed_q;
  assign wb_last    = (state == ST_WBACK) && mem_ack && (beat == LAST);
  assign fill_last  = (state == ST_FILL)  && mem_ack && (beat == LAST);

  always_comb begin
    state_d = state;
    unique case (state)
      ST_IDLE:  if (cpu_req) state_d = ST_CMP;
      ST_CMP: begin
        if (lookup_hit)                state_d = ST_IDLE;
        else if (lk_valid && lk_dirty) state_d = ST_WBACK;
        else                           state_d = ST_FILL;
      end
      ST_WBACK: if (wb_last)   state_d = ST_FILL;
      ST_FILL:  if (fill_last) state_d = ST_CMP;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      beat     <= '0;
      missed_q <= 1'b0;
    end else begin
      state <= state_d;
      if (state == ST_CMP) beat <= '0;
      else if ((state == ST_WBACK || state == ST_FILL) && mem_ack)
        beat <= (beat == LAST) ? '0 : beat + 1'b1;
      if (accept) missed_q <= 1'b0;
      else if (state == ST_CMP && !lookup_hit) missed_q <= 1'b1;
    end
  end
endmodule

// File: rtl/dm_wb_cache.sv
module dm_wb_cache
  import cache_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int LINE_BYTES = 32,
  parameter int LINES      = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cpu_req,
  input  logic                         cpu_we,
  input  logic [ADDR_W-1:0]            cpu_addr,
  input  logic [cache_pkg::WORD_W-1:0] cpu_wdata,
  input  logic [cache_pkg::BE_W-1:0]   cpu_be,
  output logic                         cpu_ready,
  output logic                         cpu_hit,
  output logic [cache_pkg::WORD_W-1:0] cpu_rdata,
  output logic                         mem_req,
  output logic                         mem_we,
  output logic [ADDR_W-1:0]            mem_addr,
  output logic [cache_pkg::WORD_W-1:0] mem_wdata,
  input  logic                         mem_ack,
  input  logic [cache_pkg::WORD_W-1:0] mem_rdata
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(LINES);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int WPL    = LINE_BYTES / BE_W;
  localparam int WSEL_W = $clog2(WPL);
  localparam int BSEL_W = $clog2(BE_W);

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction
  function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction
  function automatic logic [WSEL_W-1:0] word_of(input logic [ADDR_W-1:0] a);
    return a[BSEL_W +: WSEL_W];
  endfunction

  // latched request
  logic              q_we;
  logic [ADDR_W-1:0] q_addr;
  logic [WORD_W-1:0] q_wdata;
  logic [BE_W-1:0]   q_be;

  // controller
  cstate_t           state;
  logic [WSEL_W-1:0] beat;
  logic              accept, hit_done, first_hit;
  logic              evt_wb_last, evt_fill_last;

  // lookup
  logic              lk_valid, lk_dirty, lk_match;
  logic [TAG_W-1:0]  lk_tag;
  logic [IDX_W-1:0]  q_idx;
  logic [TAG_W-1:0]  q_tag;

  // data store
  logic [WSEL_W-1:0] rd_sel, wr_sel;
  logic [WORD_W-1:0] rd_word, wr_data;
  logic [BE_W-1:0]   wr_be;
  logic              wr_en;
  logic              evt_fill_beat, evt_write_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_we    <= 1'b0;
      q_addr  <= '0;
      q_wdata <= '0;
      q_be    <= '0;
    end else if (accept) begin
      q_we    <= cpu_we;
      q_addr  <= cpu_addr;
      q_wdata <= cpu_wdata;
      q_be    <= cpu_be;
    end
  end

  assign q_idx    = idx_of(q_addr);
  assign q_tag    = tag_of(q_addr);
  assign lk_match = (lk_tag == q_tag);

  cache_ctrl #(.WPL(WPL), .WSEL_W(WSEL_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_req   (cpu_req),
    .lk_valid  (lk_valid),
    .lk_dirty  (lk_dirty),
    .lk_match  (lk_match),
    .mem_ack   (mem_ack),
    .state     (state),
    .beat      (beat),
    .accept    (accept),
    .hit_done  (hit_done),
    .first_hit (first_hit),
    .wb_last   (evt_wb_last),
    .fill_last (evt_fill_last)
  );

  assign evt_write_hit = hit_done && q_we;
  assign evt_fill_beat = (state == ST_FILL) && mem_ack;

  cache_tag_store #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk        (clk),
    .rst_n      (rst_n),
    .idx        (q_idx),
    .fill_en    (evt_fill_last),
    .fill_tag   (q_tag),
    .mark_dirty (evt_write_hit),
    .lk_valid   (lk_valid),
    .lk_dirty   (lk_dirty),
    .lk_tag     (lk_tag)
  );

  assign rd_sel  = (state == ST_WBACK) ? beat : word_of(q_addr);
  assign wr_en   = evt_fill_beat || evt_write_hit;
  assign wr_sel  = evt_fill_beat ? beat : word_of(q_addr);
  assign wr_data = evt_fill_beat ? mem_rdata : q_wdata;
  assign wr_be   = evt_fill_beat ? {BE_W{1'b1}} : q_be;

  cache_data_store #(.LINES(LINES), .WPL(WPL), .IDX_W(IDX_W), .WSEL_W(WSEL_W)) u_data (
    .clk     (clk),
    .rd_idx  (q_idx),
    .rd_sel  (rd_sel),
    .rd_word (rd_word),
    .wr_en   (wr_en),
    .wr_idx  (q_idx),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .wr_be   (wr_be)
  );

  assign cpu_ready = hit_done;
  assign cpu_hit   = first_hit;
  assign cpu_rdata = rd_word;

  assign mem_req   = (state == ST_WBACK) || (state == ST_FILL);
  assign mem_we    = (state == ST_WBACK);
  assign mem_addr  = {(state == ST_WBACK) ? lk_tag : q_tag, q_idx, beat, {BSEL_W{1'b0}}};
  assign mem_wdata = rd_word;
endmodule

// File: rtl/cache_sva.sv
module cache_sva #(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 5,
  parameter int WSEL_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_ready,
  input logic              cpu_hit,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              evt_wb_last,
  input logic              evt_fill_last
);
  localparam logic [WSEL_W-1:0] LAST = {WSEL_W{1'b1}};
  logic [WSEL_W-1:0] sel_now;
  assign sel_now = mem_addr[OFF_W-1:2];

  // R10
  ready_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> !mem_req);

  // R10
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  // R5
  beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && (sel_now != LAST) |=>
      mem_req && (mem_we == $past(mem_we)) && (sel_now == WSEL_W'($past(sel_now) + 1'b1)));

  // R5
  word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00));

  // R6
  wb_then_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_wb_last |=> mem_req && !mem_we && (sel_now == '0));

  // R5
  fill_then_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_fill_last |=> cpu_ready && !cpu_hit);

  // R3
  hit_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_hit |-> cpu_ready);
endmodule

bind dm_wb_cache cache_sva #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .WSEL_W(WSEL_W)) u_sva (
  .clk           (clk),
  .rst_n         (rst_n),
  .cpu_ready     (cpu_ready),
  .cpu_hit       (cpu_hit),
  .mem_req       (mem_req),
  .mem_we        (mem_we),
  .mem_ack       (mem_ack),
  .mem_addr      (mem_addr),
  .evt_wb_last   (evt_wb_last),
  .evt_fill_last (evt_fill_last)
);

// File: tb/dm_wb_cache_bench.sv
module dm_wb_cache_bench;
  localparam int AW   = 16;
  localparam int MEMW = 1 << (AW - 2);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic [3:0]  cpu_be = '0;
  logic        cpu_ready, cpu_hit;
  logic [31:0] cpu_rdata;
  logic        mem_req, mem_we, mem_ack;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;

  logic [31:0] bmem [MEMW];
  logic [31:0] emem [MEMW];

  always #4 clk = ~clk;

  assign mem_ack   = mem_req;
  assign mem_rdata = bmem[mem_addr[AW-1:2]];

  dm_wb_cache #(.ADDR_W(AW)) u_dm_wb_cache (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_be(cpu_be), .cpu_ready(cpu_ready), .cpu_hit(cpu_hit),
    .cpu_rdata(cpu_rdata), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int n_chk = 0, n_fail = 0;

  function automatic logic [31:0] pat(input int i);
    return (i * 32'h0100_0193) ^ 32'h5A5A_0000;
  endfunction

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // reference model of the cache state
  logic        mv [16];
  logic        md [16];
  logic [6:0]  mt [16];
  logic [31:0] mdat [16][8];
  logic        e_hit, e_wb;
  logic [31:0] e_rdata;
  logic [AW-1:0] e_wb_base, e_fill_base;

  task automatic mdl_access(input logic we, input logic [AW-1:0] a,
                            input logic [31:0] wd, input logic [3:0] be);
    logic [3:0] ix;
    logic [6:0] tg;
    logic [2:0] w;
    ix = a[8:5]; tg = a[15:9]; w = a[4:2];
    e_hit = mv[ix] && (mt[ix] == tg);
    e_wb = 1'b0;
    e_wb_base = {mt[ix], ix, 5'b0};
    e_fill_base = {a[15:5], 5'b0};
    if (!e_hit) begin
      if (mv[ix] && md[ix]) begin
        e_wb = 1'b1;
        for (int k = 0; k < 8; k++) emem[(e_wb_base >> 2) + k] = mdat[ix][k];
      end
      for (int k = 0; k < 8; k++) mdat[ix][k] = emem[(e_fill_base >> 2) + k];
      mv[ix] = 1'b1; mt[ix] = tg; md[ix] = 1'b0;
    end
    e_rdata = mdat[ix][w];
    if (we) begin
      for (int b = 0; b < 4; b++) if (be[b]) mdat[ix][w][8*b +: 8] = wd[8*b +: 8];
      md[ix] = 1'b1;
    end
  endtask

  // results of one access
  logic g_hit;
  logic [31:0] g_rdata;
  int g_rd, g_wr, g_cyc, g_aerr;

  task automatic do_access(input logic we, input logic [AW-1:0] a,
                           input logic [31:0] wd, input logic [3:0] be);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd; cpu_be = be;
    g_rd = 0; g_wr = 0; g_cyc = 0; g_aerr = 0; g_hit = 1'b0; g_rdata = '0;
    for (int t = 0; t < 100; t++) begin
      @(negedge clk);
      g_cyc++;
      if (mem_req && mem_ack) begin
        if (mem_we) begin
          if (mem_addr != e_wb_base + AW'(4 * g_wr)) g_aerr++;
          bmem[mem_addr[AW-1:2]] = mem_wdata;
          g_wr++;
        end else begin
          if (mem_addr != e_fill_base + AW'(4 * g_rd)) g_aerr++;
          g_rd++;
        end
      end
      if (cpu_ready) begin
        g_hit = cpu_hit; g_rdata = cpu_rdata;
        cpu_req = 1'b0;
        break;
      end
    end
    if (cpu_req) begin
      chk(1'b0, "R10 access never completed", 32'(g_cyc), 32'd0);
      cpu_req = 1'b0;
    end
  endtask

  task automatic run_one(input logic we, input logic [AW-1:0] a, input logic [31:0] wd,
                         input logic [3:0] be, input logic x_hit, input logic x_wb, input string tg);
    int xc;
    mdl_access(we, a, wd, be);
    do_access(we, a, wd, be);
    xc = x_hit ? 1 : (x_wb ? 18 : 10);
    chk(g_hit == x_hit, {tg, " R2 hit flag"}, 32'(g_hit), 32'(x_hit));
    chk(e_hit == x_hit, {tg, " R2 model agrees with table"}, 32'(e_hit), 32'(x_hit));
    chk(g_cyc == xc, {tg, " R3/R5 latency"}, 32'(g_cyc), 32'(xc));
    chk(g_rd == (x_hit ? 0 : 8), {tg, " R5/R8 refill beats"}, 32'(g_rd), x_hit ? 32'd0 : 32'd8);
    chk(g_wr == (x_wb ? 8 : 0), {tg, " R6/R7/R4 write-back beats"}, 32'(g_wr), x_wb ? 32'd8 : 32'd0);
    chk(g_aerr == 0, {tg, " R5/R6 beat addresses"}, 32'(g_aerr), 32'd0);
    if (!we) chk(g_rdata == e_rdata, {tg, " R9 read data"}, g_rdata, e_rdata);
  endtask

  typedef struct packed {
    logic        we;
    logic [15:0] addr;
    logic [31:0] wdata;
    logic [3:0]  be;
    logic        hit;
    logic        wb;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 16'd1090, 32'h0,          4'h0, 1'b0, 1'b0},
    '{1'b0, 16'd1440, 32'h0,          4'h0, 1'b0, 1'b0},
    '{1'b0, 16'd5000, 32'h0,          4'h0, 1'b0, 1'b0},
    '{1'b0, 16'd1470, 32'h0,          4'h0, 1'b1, 1'b0},
    '{1'b0, 16'd1600, 32'h0,          4'h0, 1'b0, 1'b0},
    '{1'b1, 16'd256,  32'h1122_3344,  4'hF, 1'b0, 1'b0},
    '{1'b1, 16'd1620, 32'hAABB_CCDD,  4'h2, 1'b1, 1'b0},
    '{1'b1, 16'd1099, 32'h5566_7788,  4'hC, 1'b0, 1'b1},
    '{1'b0, 16'd1620, 32'h0,          4'h0, 1'b0, 1'b1},
    '{1'b0, 16'd256,  32'h0,          4'h0, 1'b1, 1'b0},
    '{1'b0, 16'd1088, 32'h0,          4'h0, 1'b0, 1'b0},
    '{1'b0, 16'd1099, 32'h0,          4'h0, 1'b1, 1'b0}
  };

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    int bad;
    for (int i = 0; i < MEMW; i++) begin bmem[i] = pat(i); emem[i] = pat(i); end
    for (int i = 0; i < 16; i++) begin mv[i] = 1'b0; md[i] = 1'b0; mt[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle after reset
    chk(cpu_ready == 1'b0, "R1 ready low after reset", 32'(cpu_ready), 32'd0);
    chk(mem_req == 1'b0, "R1 mem_req low after reset", 32'(mem_req), 32'd0);

    for (int v = 0; v < NV; v++) begin
      run_one(VEC[v].we, VEC[v].addr, VEC[v].wdata, VEC[v].be, VEC[v].hit, VEC[v].wb,
              $sformatf("vec%0d", v));
    end

    // R4: written line at 256 is still dirty in the cache, memory untouched
    chk(bmem[64] == pat(64), "R4 no write-through at 256", bmem[64], pat(64));
    // R6/R8: merged bytes of 1620 reached memory on eviction
    chk(bmem[405] == emem[405], "R6 evicted merged word 1620", bmem[405], emem[405]);
    bad = 0;
    for (int i = 0; i < MEMW; i++) if (bmem[i] != emem[i]) bad++;
    chk(bad == 0, "R6/R7 backing memory image", 32'(bad), 32'd0);

    // R1: reset mid-run invalidates all lines and drops dirty data
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(cpu_ready == 1'b0 && mem_req == 1'b0, "R1 outputs idle in reset", 32'(mem_req), 32'd0);
    rst_n = 1'b1;
    for (int i = 0; i < 16; i++) begin mv[i] = 1'b0; md[i] = 1'b0; end
    run_one(1'b0, 16'd256, 32'h0, 4'h0, 1'b0, 1'b0, "R1 re-reset 256");
    chk(g_rdata == pat(64), "R1 dirty data dropped by reset", g_rdata, pat(64));
    run_one(1'b0, 16'd1470, 32'h0, 4'h0, 1'b0, 1'b0, "R1 re-reset 1470");
    // R2: same index, other tag, then offset-only difference
    run_one(1'b0, 16'd1440 + 16'd512, 32'h0, 4'h0, 1'b0, 1'b0, "R2 tag conflict");
    run_one(1'b1, 16'd1952 + 16'd28, 32'hDEAD_BEEF, 4'h9, 1'b1, 1'b0, "R4 partial write hit");
    run_one(1'b0, 16'd1952 + 16'd30, 32'h0, 4'h0, 1'b1, 1'b0, "R4 partial merge read");
    run_one(1'b1, 16'd1440, 32'h0102_0304, 4'hF, 1'b0, 1'b1, "R8 write miss dirty victim");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule